// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block is the management-interface master of an Ethernet port. It handles clause 22 only. Software sees four 32-bit registers. The first packs the target PHY address, the PHY register number and a read/write flag. The second holds the 16 bits to write. The third returns the 16 bits read from the PHY. The fourth holds an enable bit and a go/status bit that the hardware clears itself.

Software programs the command registers and then writes the control register with both the enable bit and the status bit set. The block serialises a complete frame on the management line. It produces MDC from the system clock through a parameterised divider. The bidirectional data line is reached through separate output, output-enable and input signals, so the pad cell and its pull-up sit outside the block. While the status bit reads 1 the transaction is still running. When the last bit has been clocked, the status bit drops and any read result is ready.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command register at byte offset 0x7E4 holds bits 10:0. Bits 4:0 are the PHY register number, bits 9:5 are the PHY address, and bit 10 is the operation (1 = read, 0 = write). A read returns the written bits 10:0 with all upper bits 0.
- R2: The write-data register at offset 0x7E8 holds bits 15:0 and reads back with bits 31:16 equal to 0. The read-data register at offset 0x7EC returns the last 16 bits captured from the PHY in bits 15:0.
- R3: In the control register at offset 0x7F0, bit 3 is the enable and bit 0 is the status. A write made while no transaction runs stores bit 3, and bit 3 reads back as stored.
- R4: Writing the control register with bits 0 and 3 both set, while idle, starts a transaction. Status reads 1 from the next cycle. Status falls in the same cycle as the MDC falling edge that follows the 64th rising edge of the frame.
- R5: A control write with bit 0 set and bit 3 clear starts nothing. Status stays 0 and the output enable stays low.
- R6: A control write made while status is 1 is ignored. Enable and status keep their values, and the running frame is not disturbed.
- R7: MDC runs continuously, with HALF_DIV system clocks low and then HALF_DIV system clocks high. It is low when reset is released.
- R8: The data output changes only in the system-clock cycle in which MDC falls.
- R9: A write frame drives 64 bits, MSB first, each valid at an MDC rising edge, in this order: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and the 16 data bits.
- R10: A read frame drives 32 ones, start 01, opcode 10, the PHY address and the register number (46 bits). It then holds the output enable low for the remaining 18 bit times. Data bits 15..0 are sampled at the last 16 MDC rising edges and stored in the read-data register.
- R11: A read from an absent PHY, where the line is left pulled high, returns 0xFFFF.
- R12: After reset all registers read 0, status is 0, MDC is 0 and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (pad, pulled up) |

## Verification
- **Clock and output timing.** MDC follows from the number of system clocks since reset. The bench predicts its level at every clock and compares it there. On every clock the bench also checks that the data output moves only in a cycle in which MDC has just fallen.
- **Frame content.** Frame bits are captured at each MDC rising edge and compared against the expected frame afterwards.
- **Completion timing.** Completion is due at the MDC falling edge after the 64th rising edge. The bench watches status on every clock from the 64th rise onward: it must still read 1 up to that fall and read 0 in the same cycle. The read-data register is read after that cycle.
- **Register accesses.** Register writes take effect at the next clock edge. Read-back is sampled in the following low clock phase.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants and types of the MDIO management master.
// Assumes byte offsets fit in 12 bits; all frame positions are clause 22.
package mdio_mgmt_pkg;
    localparam logic [11:0] OFF_CMD   = 12'h7E4;
    localparam logic [11:0] OFF_WDATA = 12'h7E8;
    localparam logic [11:0] OFF_RDATA = 12'h7EC;
    localparam logic [11:0] OFF_CTRL  = 12'h7F0;

    localparam int CTRL_STATUS_BIT = 0;
    localparam int CTRL_ENABLE_BIT = 3;

    localparam int FRAME_BITS  = 64;
    localparam int PRE_BITS    = 32;
    localparam int TA_FIRST    = 46;
    localparam int DATA_FIRST  = 48;
    localparam int CNT_W       = $clog2(FRAME_BITS);

    typedef struct packed {
        logic       rd;
        logic [4:0] phy;
        logic [4:0] regn;
        logic [15:0] wdat;
    } mdio_cmd_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
// Free-running MDC generator.
// Produces MDC with HALF_DIV system clocks per phase, plus one-cycle strobes
// that are high in the cycle before MDC rises or falls. Assumes HALF_DIV >= 2.
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          term;

    assign term     = (cnt_q == LAST);
    assign rise_stb = term && !mdc_q;
    assign fall_stb = term && mdc_q;
    assign mdc      = mdc_q;

    // Phase counter: toggles MDC at the end of every half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r7_mdc_toggles_on_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc_q) |-> ($past(cnt_q) == LAST));

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));
endmodule

// File: rtl/mdio_frame_engine.sv
// Serialises one clause 22 frame per start pulse.
// Latches the command when started, begins at the next MDC falling strobe,
// updates the data output only on falling strobes and samples read data on
// rising strobes. Assumes start is only pulsed while busy is low.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        mdc_i,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    output logic        busy,
    output logic [15:0] rd_data,
    output logic        mdo,
    output logic        mdo_oe
);
    eng_state_t             st_q;
    mdio_cmd_t              cmd_q;
    logic [FRAME_BITS-1:0]  sh_q;
    logic [CNT_W-1:0]       bit_q;
    logic [15:0]            cap_q;
    logic [15:0]            rd_q;
    logic                   mdo_q;
    logic                   oe_q;
    logic [FRAME_BITS-1:0]  frame;
    logic                   last_bit;
    logic                   next_released;

    // Assembled frame for the latched command, MSB first.
    always_comb begin
        frame = {{PRE_BITS{1'b1}}, 2'b01,
                 (cmd_q.rd ? 2'b10 : 2'b01),
                 cmd_q.phy, cmd_q.regn, 2'b10,
                 (cmd_q.rd ? 16'h0000 : cmd_q.wdat)};
    end

    assign last_bit      = (bit_q == CNT_W'(FRAME_BITS - 1));
    assign next_released = cmd_q.rd && ((32'(bit_q) + 1) >= TA_FIRST);

    // Frame sequencer: wait for a falling strobe, then shift one bit per MDC period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ENG_IDLE;
            cmd_q <= '0;
            sh_q  <= '0;
            bit_q <= '0;
            cap_q <= '0;
            rd_q  <= '0;
            mdo_q <= 1'b1;
            oe_q  <= 1'b0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        cmd_q <= cmd;
                        st_q  <= ENG_WAIT;
                    end
                end
                ENG_WAIT: begin
                    if (fall_stb) begin
                        mdo_q <= frame[FRAME_BITS-1];
                        sh_q  <= frame << 1;
                        oe_q  <= 1'b1;
                        bit_q <= '0;
                        st_q  <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (rise_stb && cmd_q.rd && (32'(bit_q) >= DATA_FIRST)) begin
                        cap_q <= {cap_q[14:0], mdio_in};
                    end
                    if (fall_stb) begin
                        if (last_bit) begin
                            st_q  <= ENG_IDLE;
                            oe_q  <= 1'b0;
                            mdo_q <= 1'b1;
                            if (cmd_q.rd) begin
                                rd_q <= cap_q;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            mdo_q <= sh_q[FRAME_BITS-1];
                            sh_q  <= sh_q << 1;
                            oe_q  <= !next_released;
                        end
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy    = (st_q != ENG_IDLE);
    assign rd_data = rd_q;
    assign mdo     = mdo_q;
    assign mdo_oe  = oe_q;

    a_r8_output_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdo_q) |-> $fell(mdc_i));

    a_r10_released_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENG_RUN && cmd_q.rd && 32'(bit_q) >= TA_FIRST) |-> !oe_q);

    a_r4_ends_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bit_q) == CNT_W'(FRAME_BITS - 1)));

    a_r8_no_drive_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !oe_q);
endmodule

// File: rtl/mdio_reg_bank.sv
// Software-visible registers of the MDIO master.
// Decodes writes, produces the start pulse and the combinational read mux.
// Assumes busy reflects the engine state and doubles as the status bit.
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy_i,
    input  logic [15:0]       rd_data_i,
    output mdio_cmd_t         cmd,
    output logic              start
);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFF_WDATA);
    localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFF_RDATA);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);

    logic [10:0] cmd_q;
    logic [15:0] wdat_q;
    logic        en_q;
    logic        ctrl_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL) && !busy_i;
    assign start   = ctrl_wr && wdata[CTRL_STATUS_BIT] && wdata[CTRL_ENABLE_BIT];
    assign cmd     = '{rd: cmd_q[10], phy: cmd_q[9:5], regn: cmd_q[4:0], wdat: wdat_q};

    // Register writes; the control word is locked while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            wdat_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CMD)   cmd_q  <= wdata[10:0];
            if (addr == A_WDATA) wdat_q <= wdata[15:0];
            if (ctrl_wr)         en_q   <= wdata[CTRL_ENABLE_BIT];
        end
    end

    // Read mux over the four registers.
    always_comb begin
        rdata = '0;
        if (addr == A_CMD)   rdata = {21'd0, cmd_q};
        if (addr == A_WDATA) rdata = {16'd0, wdat_q};
        if (addr == A_RDATA) rdata = {16'd0, rd_data_i};
        if (addr == A_CTRL) begin
            rdata[CTRL_ENABLE_BIT] = en_q;
            rdata[CTRL_STATUS_BIT] = busy_i;
        end
    end

    a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> en_q);

    a_r6_enable_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable(en_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
// Top of the register-controlled clause 22 management master.
// Ties the register bank, the MDC divider and the frame engine together.
// Assumes ADDR_W >= 11 so that every register offset is decodable.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_cmd_t   cmd;
    logic        start;
    logic        busy;
    logic [15:0] rd_data;
    logic        rise_stb;
    logic        fall_stb;
    logic        mdc_w;

    mdio_reg_bank #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy_i(busy),
        .rd_data_i(rd_data), .cmd(cmd), .start(start)
    );

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .mdc(mdc_w),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .mdc_i(mdc_w),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_in(mdio_i),
        .busy(busy), .rd_data(rd_data), .mdo(mdio_o), .mdo_oe(mdio_oe)
    );

    assign mdc = mdc_w;

    a_r4_status_set_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: tb/mdio_mgmt_master_test.sv
// Self-checking bench: behavioural MDC/PHY model compared on every clock.
module mdio_mgmt_master_test;
    localparam int HALF = 4;
    localparam logic [11:0] A_CMD = 12'h7E4, A_WD = 12'h7E8, A_RD = 12'h7EC, A_CT = 12'h7F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic mdc, mdio_o, mdio_oe;
    wire  mdio_line;

    int tests = 0, fails = 0;
    int n_edges = 0, wd = 0;
    int idx = 0;
    bit in_frame = 0, frame_done = 0, watch_end = 0, oe_seen = 0, monitor_on = 0;
    bit phy_on = 0, rd_sel = 0;
    logic [15:0] phy_word = '0;
    logic prev_mdc = 1'b0, prev_mdo = 1'b1;
    logic [63:0] cap_bit, cap_oe;

    always #10 clk = !clk;

    mdio_mgmt_master #(.ADDR_W(12), .HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // PHY model: answers read data bits 48..63, else the pull-up holds the line high.
    assign mdio_line = mdio_oe ? mdio_o :
        ((phy_on && rd_sel && idx >= 48 && idx < 64) ? phy_word[4'(63 - idx)] : 1'b1);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst_n) n_edges++; else n_edges = 0;
        wd++;
        if (wd > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Per-clock reference comparison, away from the active edge.
    always @(negedge clk) begin
        if (monitor_on) begin
            check(mdc == 1'((n_edges / HALF) % 2), "R7 mdc level", 64'(mdc), 64'((n_edges / HALF) % 2));
            check(mdio_o == prev_mdo || (prev_mdc && !mdc), "R8 data moved off fall", 64'(mdio_o), 64'(prev_mdo));
            if (mdio_oe) oe_seen = 1;
            if (!prev_mdc && mdc) begin
                if (!in_frame && mdio_oe) begin
                    in_frame = 1;
                    idx = 0;
                end
                if (in_frame && idx < 64) begin
                    cap_bit[63 - idx] = mdio_line;
                    cap_oe[63 - idx]  = mdio_oe;
                    idx++;
                end
            end
            if (watch_end) begin
                if (prev_mdc && !mdc) begin
                    check(bus_rdata[0] == 1'b0, "R4 status clears at final fall", 64'(bus_rdata[0]), 64'd0);
                    watch_end = 0;
                    in_frame = 0;
                    frame_done = 1;
                end else begin
                    check(bus_rdata[0] == 1'b1, "R4 status held to frame end", 64'(bus_rdata[0]), 64'd1);
                end
            end
            prev_mdc = mdc;
            prev_mdo = mdio_o;
        end
    end

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Launches one frame and checks content and completion timing.
    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rn,
                             input logic [15:0] wdat, input bit present, input logic [15:0] pw,
                             input bit poke_ctrl);
        logic [31:0] v;
        logic [63:0] exp;
        int bad;
        rd_sel = rd; phy_on = present; phy_word = pw;
        frame_done = 0;
        reg_write(A_CMD, {21'd0, rd, phy, rn});
        reg_write(A_WD, {16'd0, wdat});
        reg_write(A_CT, 32'h9);
        reg_read(A_CT, v);
        check(v == 32'h9, "R4 status set after start", 64'(v), 64'h9);
        if (poke_ctrl) begin
            wait (idx >= 20 && in_frame);
            reg_write(A_CT, 32'h0);
            reg_read(A_CT, v);
            check(v == 32'h9, "R6 control write ignored while busy", 64'(v), 64'h9);
        end
        wait (in_frame && idx == 64);
        @(posedge clk); #3;
        bus_addr = A_CT;
        watch_end = 1;
        wait (frame_done);
        exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rn, 2'b10, wdat};
        bad = 0;
        for (int i = 63; i >= 0; i--) begin
            if (!rd || i >= 18) begin
                if (cap_bit[i] !== exp[i] || cap_oe[i] !== 1'b1) bad++;
            end else if (cap_oe[i] !== 1'b0) bad++;
        end
        if (rd) check(bad == 0, "R10 read header and release", cap_bit, exp);
        else    check(bad == 0, "R9 write frame bits", cap_bit, exp);
        if (rd) begin
            reg_read(A_RD, v);
            if (present) check(v == {16'd0, pw}, "R10 captured read data", 64'(v), 64'(pw));
            else         check(v == 32'h0000_FFFF, "R11 absent phy reads all ones", 64'(v), 64'hFFFF);
        end
        reg_read(A_CT, v);
        check(v == 32'h8, "R6 enable kept, status clear after frame", 64'(v), 64'h8);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        monitor_on = 1;
        reg_read(A_CMD, v); check(v == 0, "R12 command reg reset", 64'(v), 0);
        reg_read(A_WD, v);  check(v == 0, "R12 write data reset", 64'(v), 0);
        reg_read(A_RD, v);  check(v == 0, "R12 read data reset", 64'(v), 0);
        reg_read(A_CT, v);  check(v == 0, "R12 control reset", 64'(v), 0);
        check(mdio_oe == 1'b0, "R12 output enable low", 64'(mdio_oe), 0);

        reg_write(A_CMD, 32'hFFFF_F7A5);
        reg_read(A_CMD, v); check(v == 32'h7A5, "R1 command field readback", 64'(v), 64'h7A5);
        reg_write(A_WD, 32'hDEAD_BEEF);
        reg_read(A_WD, v);  check(v == 32'hBEEF, "R2 write data readback", 64'(v), 64'hBEEF);
        reg_write(A_CT, 32'h8);
        reg_read(A_CT, v);  check(v == 32'h8, "R3 enable readback", 64'(v), 64'h8);

        // R5: go without enable starts nothing.
        oe_seen = 0;
        reg_write(A_CT, 32'h1);
        repeat (4 * HALF) @(negedge clk);
        reg_read(A_CT, v);
        check(v == 32'h0, "R5 no start while disabled", 64'(v), 0);
        check(oe_seen == 0, "R5 line never driven", 64'(oe_seen), 0);

        run_frame(1'b0, 5'h1F, 5'h00, 16'h1234, 1'b0, 16'h0, 1'b0);
        run_frame(1'b0, 5'h00, 5'h1F, 16'h8001, 1'b0, 16'h0, 1'b1);
        run_frame(1'b1, 5'h11, 5'h02, 16'h0, 1'b1, 16'hA5C3, 1'b0);
        run_frame(1'b1, 5'h03, 5'h01, 16'h0, 1'b0, 16'h0, 1'b0);
        run_frame(1'b1, 5'h0A, 5'h15, 16'h0, 1'b1, 16'h0F01, 1'b1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule